// File: doc/BRIEF.md
# Sequential Signed Shift-Add Multiplier

This block multiplies two 8-bit two's-complement integers into a 16-bit two's-complement product. It has one adder, which it reuses over several clock cycles. A load strobe captures both operands. Each operand is reduced to its unsigned magnitude, and the sign of the product is kept as the exclusive-or of the two operand signs.

Each cycle with shift-enable high is one shift-add step. The lowest remaining multiplier bit gates the multiplicand into a partial-product row. That row is added to an accumulator, and the carry-out of the add is kept. The lowest bit of the sum moves into a register that builds the low half of the product. The carry and the upper sum bits go back into the accumulator.

After eight steps the 16-bit magnitude is negated if the sign calls for it. The result is then presented with a done flag. A full multiply takes nine cycles: one load cycle and eight steps.

Top module: `smul_seq_top`

## Requirements
- R1: The clock edge that samples `load_i` high captures both operands. After that edge `done_o` is 0 and `product_o` is 0x0000.
- R2: When `load_i` and `shift_en_i` are both high in the same cycle, the load takes effect and no step is performed. Eight further step cycles are still needed before `done_o` rises.
- R3: Each cycle with `shift_en_i` high after a load performs one step. `done_o` is 0 after seven steps and rises on the edge of the eighth step, so load plus steps take exactly nine cycles.
- R4: A cycle with both `load_i` and `shift_en_i` low changes nothing: `product_o`, `done_o` and the progress of the multiply hold. The done flag is delayed by exactly the number of stalled cycles.
- R5: With two non-negative operands, `product_o` equals their unsigned product.
- R6: When exactly one operand is negative (bit 7 set), `product_o` is the 16-bit two's-complement negation of the magnitude product. When both are negative, the product is positive.
- R7: An operand of 0x80 (-128) is treated as magnitude 128. For example, -128 × -128 gives 0x4000 and -128 × 127 gives 0xC080.
- R8: If either operand is zero, `product_o` is 0x0000, including when the other operand is negative.
- R9: Once `done_o` is 1, `product_o` and `done_o` hold until the next load. Further `shift_en_i` cycles have no effect on them.
- R10: While `rst_n` is low, `done_o` is 0 and `product_o` is 0x0000. A reset during a multiply abandons it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Captures operands and restarts the multiply |
| shift_en_i | input | 1 | Allows one shift-add step per cycle |
| mcand_i | input | 8 | Multiplicand, two's complement |
| mplier_i | input | 8 | Multiplier, two's complement |
| product_o | output | 16 | Signed product, valid while done_o is 1 |
| done_o | output | 1 | Product ready; held until the next load |

## Verification
A load and a shift-add step can both be requested in the same cycle. The bench provokes this by raising `shift_en_i` together with `load_i`, then giving exactly seven step cycles. If the load cycle had also stepped, `done_o` would already be set at that point. The bench checks that `done_o` is still 0 after those seven steps, that it rises on the eighth, and that the final product matches the signed product of the operands computed in the bench.

// File: rtl/smul_pkg.sv
package smul_pkg;

  localparam int unsigned SMUL_W_DEF = 8;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_DONE = 2'd2
  } smul_phase_e;

endpackage

// File: rtl/smul_mag.sv
module smul_mag #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] val_i,
  output logic [W-1:0] mag_o,
  output logic         neg_o
);

  always_comb begin
    neg_o = val_i[W-1];
    if (val_i[W-1]) begin
      mag_o = ~val_i + W'(1);
    end else begin
      mag_o = val_i;
    end
  end

endmodule

// File: rtl/smul_step.sv
module smul_step #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] mcand_i,
  input  logic         gate_i,
  input  logic [W-1:0] acc_i,
  output logic [W-1:0] acc_o,
  output logic         lsb_o
);

  logic [W-1:0] row;
  logic [W:0]   sum;

  always_comb begin
    row   = mcand_i & {W{gate_i}};
    sum   = {1'b0, acc_i} + {1'b0, row};
    acc_o = sum[W:1];
    lsb_o = sum[0];
  end

endmodule

// File: rtl/smul_sign_fix.sv
module smul_sign_fix #(
  parameter int unsigned PW = 16
) (
  input  logic [PW-1:0] mag_i,
  input  logic          neg_i,
  output logic [PW-1:0] res_o
);

  always_comb begin
    if (neg_i) begin
      res_o = ~mag_i + PW'(1);
    end else begin
      res_o = mag_i;
    end
  end

endmodule

// File: rtl/smul_seq_top.sv
module smul_seq_top #(
  parameter int unsigned W = smul_pkg::SMUL_W_DEF
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic           shift_en_i,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic [2*W-1:0] product_o,
  output logic           done_o
);
  import smul_pkg::*;

  localparam int unsigned PW = 2 * W;
  localparam int unsigned CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

  logic [W-1:0]  mag_a, mag_b;
  logic          neg_a, neg_b;
  logic [W-1:0]  mcand_q, mcand_d;
  logic [W-1:0]  mq_q, mq_d;
  logic [W-1:0]  acc_q, acc_d;
  logic [W-1:0]  lo_q, lo_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          neg_q, neg_d;
  logic [PW-1:0] prod_q, prod_d;
  smul_phase_e   phase_q, phase_d;
  logic [W-1:0]  acc_nx;
  logic          lsb_nx;
  logic [PW-1:0] final_mag, final_res;
  logic          step_en;

  smul_mag #(.W(W)) u_mag_a (.val_i(mcand_i),  .mag_o(mag_a), .neg_o(neg_a));
  smul_mag #(.W(W)) u_mag_b (.val_i(mplier_i), .mag_o(mag_b), .neg_o(neg_b));

  smul_step #(.W(W)) u_step (
    .mcand_i (mcand_q),
    .gate_i  (mq_q[0]),
    .acc_i   (acc_q),
    .acc_o   (acc_nx),
    .lsb_o   (lsb_nx)
  );

  assign final_mag = {acc_nx, lsb_nx, lo_q[W-1:1]};

  smul_sign_fix #(.PW(PW)) u_fix (
    .mag_i (final_mag),
    .neg_i (neg_q),
    .res_o (final_res)
  );

  assign step_en = shift_en_i && (phase_q == PH_RUN);

  always_comb begin
    mcand_d = mcand_q;
    mq_d    = mq_q;
    acc_d   = acc_q;
    lo_d    = lo_q;
    cnt_d   = cnt_q;
    neg_d   = neg_q;
    prod_d  = prod_q;
    phase_d = phase_q;
    if (load_i) begin
      mcand_d = mag_a;
      mq_d    = mag_b;
      acc_d   = '0;
      lo_d    = '0;
      cnt_d   = '0;
      neg_d   = neg_a ^ neg_b;
      prod_d  = '0;
      phase_d = PH_RUN;
    end else if (step_en) begin
      acc_d = acc_nx;
      lo_d  = {lsb_nx, lo_q[W-1:1]};
      mq_d  = mq_q >> 1;
      cnt_d = cnt_q + CW'(1);
      if (cnt_q == LAST_STEP) begin
        prod_d  = final_res;
        phase_d = PH_DONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      mq_q    <= '0;
      acc_q   <= '0;
      lo_q    <= '0;
      cnt_q   <= '0;
      neg_q   <= 1'b0;
      prod_q  <= '0;
      phase_q <= PH_IDLE;
    end else begin
      mcand_q <= mcand_d;
      mq_q    <= mq_d;
      acc_q   <= acc_d;
      lo_q    <= lo_d;
      cnt_q   <= cnt_d;
      neg_q   <= neg_d;
      prod_q  <= prod_d;
      phase_q <= phase_d;
    end
  end

  assign product_o = prod_q;
  assign done_o    = (phase_q == PH_DONE);

  // R1, R2: a load always restarts, even with shift_en_i high
  assert_load_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (!done_o && product_o == '0 && cnt_q == '0));

  // R4: an idle cycle freezes all visible state and progress
  assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !shift_en_i) |=> ($stable(product_o) && $stable(done_o) && $stable(cnt_q)));

  // R9: result holds once finished until a new load
  assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !load_i) |=> (done_o && $stable(product_o)));

  // R3: done rises only when the step counter reaches its end
  assert_done_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> (cnt_q == CW'(W) && $past(step_en)));

  // R6: a positive-signed result never has its top bit set
  assert_pos_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !neg_q) |-> !product_o[PW-1]);

  // R10: reset clears the visible outputs
  always_comb begin
    if (!rst_n) begin
      assert_reset_clear_R10: assert (!done_o && product_o == '0);
    end
  end

endmodule

// File: tb/smul_seq_top_tb.sv
module smul_seq_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        load_i;
  logic        shift_en_i;
  logic [7:0]  mcand_i;
  logic [7:0]  mplier_i;
  logic [15:0] product_o;
  logic        done_o;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  smul_seq_top #(.W(8)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_i),
    .shift_en_i (shift_en_i),
    .mcand_i    (mcand_i),
    .mplier_i   (mplier_i),
    .product_o  (product_o),
    .done_o     (done_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk16(input logic [15:0] act, input logic [15:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic chk1(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_prod(input logic [7:0] a, input logic [7:0] b);
    int p;
    p = int'($signed(a)) * int'($signed(b));
    return p[15:0];
  endfunction

  task automatic do_load(input logic [7:0] a, input logic [7:0] b, input logic sh);
    @(negedge clk);
    load_i = 1'b1; shift_en_i = sh; mcand_i = a; mplier_i = b;
    @(negedge clk);
    load_i = 1'b0; shift_en_i = 1'b0;
  endtask

  task automatic steps(input int n);
    shift_en_i = 1'b1;
    repeat (n) @(negedge clk);
    shift_en_i = 1'b0;
  endtask

  // R3 with R5/R6/R7/R8 depending on operands
  task automatic t_mult(input logic [7:0] a, input logic [7:0] b, input string req);
    do_load(a, b, 1'b0);
    chk1(done_o, 1'b0, "R1 done low after load");
    chk16(product_o, 16'h0000, "R1 product cleared by load");
    steps(7);
    chk1(done_o, 1'b0, "R3 done low after 7 steps");
    steps(1);
    chk1(done_o, 1'b1, "R3 done after 8 steps");
    chk16(product_o, ref_prod(a, b), req);
  endtask

  task automatic t_priority();
    do_load(8'd13, 8'hF5, 1'b1);
    steps(7);
    chk1(done_o, 1'b0, "R2 load cycle took no step");
    steps(1);
    chk1(done_o, 1'b1, "R2 done after 8 further steps");
    chk16(product_o, ref_prod(8'd13, 8'hF5), "R2 product with load+shift");
  endtask

  task automatic t_stall();
    do_load(8'hE7, 8'd91, 1'b0);
    steps(4);
    repeat (3) @(negedge clk);
    chk1(done_o, 1'b0, "R4 done low during stall");
    chk16(product_o, 16'h0000, "R4 product unchanged during stall");
    steps(3);
    chk1(done_o, 1'b0, "R4 stalled cycles not counted");
    steps(1);
    chk1(done_o, 1'b1, "R4 done after 8 real steps");
    chk16(product_o, ref_prod(8'hE7, 8'd91), "R4 product after stall");
  endtask

  task automatic t_hold();
    logic [15:0] keep;
    t_mult(8'd100, 8'hC4, "R6 product before hold");
    keep = product_o;
    steps(5);
    chk1(done_o, 1'b1, "R9 done held under extra shifts");
    chk16(product_o, keep, "R9 product held under extra shifts");
    repeat (4) @(negedge clk);
    chk16(product_o, keep, "R9 product held while idle");
  endtask

  task automatic t_reset_mid();
    do_load(8'd50, 8'd60, 1'b0);
    steps(3);
    rst_n = 1'b0;
    #1;
    chk1(done_o, 1'b0, "R10 done cleared in reset");
    chk16(product_o, 16'h0000, "R10 product cleared in reset");
    @(negedge clk);
    rst_n = 1'b1;
    steps(8);
    chk1(done_o, 1'b0, "R10 abandoned multiply stays idle");
  endtask

  initial begin
    rst_n = 1'b0; load_i = 1'b0; shift_en_i = 1'b0;
    mcand_i = '0; mplier_i = '0;
    repeat (2) @(negedge clk);
    chk1(done_o, 1'b0, "R10 reset done");
    chk16(product_o, 16'h0000, "R10 reset product");
    rst_n = 1'b1;
    @(negedge clk);

    t_mult(8'd7,   8'd9,   "R5 small positive");
    t_mult(8'd127, 8'd127, "R5 largest positive");
    t_mult(8'd255 - 8'd250, 8'd200 - 8'd90, "R5 mixed bits");
    t_mult(8'hFD,  8'd11,  "R6 negative times positive");
    t_mult(8'd45,  8'hB0,  "R6 positive times negative");
    t_mult(8'hF0,  8'hE9,  "R6 both negative");
    t_mult(8'h80,  8'h80,  "R7 -128 x -128");
    t_mult(8'h80,  8'd127, "R7 -128 x 127");
    t_mult(8'h80,  8'd1,   "R7 -128 x 1");
    t_mult(8'd0,   8'hC3,  "R8 zero times negative");
    t_mult(8'h80,  8'd0,   "R8 -128 times zero");
    t_mult(8'd0,   8'd0,   "R8 both zero");
    t_priority();
    t_stall();
    t_hold();
    t_reset_mid();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule